// File: doc/BRIEF.md
# Synthesizer Divider Configuration Front End

This block holds the divide settings for an integer-N frequency synthesizer and hands them to the counters. It has two 20-bit divide registers. The primary register takes new values. The secondary register holds a copy that a hop strobe takes from the primary. A select input picks which of the two drives the counters, so the loop can switch between two stored frequencies without reloading. An 8-bit enhancement register sits beside them.

The registers can be loaded in two ways. A three-wire serial port shifts a word in bit by bit. An 8-bit parallel bus has one write strobe for each slice of the word. A third mode bypasses both registers and takes the divide word straight from dedicated pins. All port strobes and data are brought into the system clock domain through a synchronizer chain, and each strobe acts once, on its rising edge. The output selection itself is combinational on the mode, select and enhancement-enable pins.

Top module: `synth_cfg_frontend`

## Requirements
- R1: After reset the primary, secondary and enhancement registers are all zero.
- R2: In serial mode, each rising edge of `ser_clk` seen while `ser_load_n` is low and `enh_wr` is low shifts `ser_data` into bit 0 of the primary register. Earlier bits move toward the MSB, so the word is entered MSB first.
- R3: In serial mode, the same shift with `enh_wr` high goes into the 8-bit enhancement register instead, MSB first, and leaves the primary register alone.
- R4: In serial mode, a rising edge of `ser_load_n` copies the primary register into the secondary register.
- R5: In serial or parallel mode, a rising edge of `hop_wr` copies the primary register into the secondary register.
- R6: With `fsel`=1, `div_word` shows the primary register. With `fsel`=0, it shows the secondary register.
- R7: In parallel mode, each rising strobe writes one slice of the primary register. `pwr_lo` writes `pbus` to bits [7:0] (A in [3:0], R[3:0] in [7:4]). `pwr_mid` writes `pbus` to bits [15:8] (M[6:0] in [14:8], prescaler enable in [15]). `pwr_hi` writes `pbus[3:0]` to bits [19:16] (M[8:7] in [17:16], R[5:4] in [19:18]). Each strobe leaves the other bits unchanged.
- R8: In parallel mode, a rising edge of `enh_wr` loads `pbus` into the enhancement register.
- R9: The mode decode is: `mode_direct`=1 selects direct mode; `mode_direct`=0 with `mode_serial`=1 selects serial mode; both 0 select parallel mode. Strobes that belong to the other loading mode change no register.
- R10: In direct mode, `div_word` equals `direct_word` combinationally for either `fsel`. No strobe given during direct mode changes any register.
- R11: `enh_bits` shows the enhancement register only while `enh_en_n` is low and the block is not in direct mode. Otherwise it reads zero.
- R12: In serial mode, `ser_clk` edges seen while `ser_load_n` is high change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_direct | input | 1 | Direct (hard-wired) mode select |
| mode_serial | input | 1 | Serial (1) or parallel (0) loading when not direct |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load_n | input | 1 | Serial shift enable, active low; rising edge copies primary to secondary |
| enh_wr | input | 1 | Serial: routes shifts to enhancement register; parallel: rising edge latches bus |
| pwr_lo | input | 1 | Parallel strobe for word bits [7:0] |
| pwr_mid | input | 1 | Parallel strobe for word bits [15:8] |
| pwr_hi | input | 1 | Parallel strobe for word bits [19:16] |
| hop_wr | input | 1 | Copy primary into secondary on rising edge |
| pbus | input | 8 | Parallel data bus |
| fsel | input | 1 | Active word select: 1 primary, 0 secondary |
| enh_en_n | input | 1 | Enhancement output enable, active low |
| direct_word | input | 20 | Divide word used in direct mode |
| div_word | output | 20 | Divide word to the counters |
| enh_bits | output | 8 | Enhancement bits to the counters |

## Verification
The bench builds the block with its default 8-bit bus and 4-bit top slice, so the 20-bit word layout and every strobe slice are exercised exactly. It raises the synchronizer depth to three stages. Every step waits long enough for a deeper chain, which shows that the loading behaviour does not depend on the latency. Random partial serial loads of 1 to 20 bits reach the states in which old primary bits are still partly present. Direct-mode episodes with strobes pulsed inside them reach the case in which stored state must survive a mode that ignores it.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    typedef enum logic [1:0] {
        MODE_PAR = 2'd0,
        MODE_SER = 2'd1,
        MODE_DIR = 2'd2
    } cfg_mode_e;

    function automatic cfg_mode_e decode_mode(input logic direct_lvl, input logic serial_lvl);
        if (direct_lvl) begin
            return MODE_DIR;
        end
        return serial_lvl ? MODE_SER : MODE_PAR;
    endfunction

endpackage

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
    parameter int W      = 18,
    parameter int EDGE_W = 7,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      raw_in,
    output logic [W-1:0]      level,
    output logic [EDGE_W-1:0] rise
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [EDGE_W-1:0]        prev;
    } sync_t;

    sync_t state_d, state_q;

    always_comb begin
        state_d          = state_q;
        state_d.chain[0] = raw_in;
        for (int i = 1; i < STAGES; i++) begin
            state_d.chain[i] = state_q.chain[i-1];
        end
        state_d.prev = state_q.chain[STAGES-1][EDGE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign level = state_q.chain[STAGES-1];
    assign rise  = state_q.chain[STAGES-1][EDGE_W-1:0] & ~state_q.prev;

    for (genvar g = 0; g < EDGE_W; g++) begin : g_edge_chk
        AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]); // R9
    end

endmodule

// File: rtl/cfg_word_store.sv
module cfg_word_store
    import synth_cfg_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int HI_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  cfg_mode_e               mode,
    input  logic                    sclk_rise,
    input  logic                    sdata,
    input  logic                    load_lvl,
    input  logic                    load_rise,
    input  logic                    ewr_lvl,
    input  logic                    ewr_rise,
    input  logic                    lo_rise,
    input  logic                    mid_rise,
    input  logic                    hi_rise,
    input  logic                    hop_rise,
    input  logic [BUS_W-1:0]        pbus,
    output logic [2*BUS_W+HI_W-1:0] pri_q,
    output logic [2*BUS_W+HI_W-1:0] sec_q,
    output logic [BUS_W-1:0]        enh_q
);

    localparam int WORD_W = 2*BUS_W + HI_W;
    localparam int MID_LO = BUS_W;
    localparam int HI_LO  = 2*BUS_W;

    typedef struct packed {
        logic [WORD_W-1:0] pri;
        logic [WORD_W-1:0] sec;
        logic [BUS_W-1:0]  enh;
    } store_t;

    store_t store_d, store_q;
    logic   shift_ok;
    logic   copy_ok;

    always_comb begin
        store_d  = store_q;
        shift_ok = (mode == MODE_SER) && sclk_rise && !load_lvl;
        copy_ok  = (mode != MODE_DIR) && (hop_rise || ((mode == MODE_SER) && load_rise));

        if (shift_ok) begin
            if (ewr_lvl) begin
                store_d.enh = {store_q.enh[BUS_W-2:0], sdata};
            end else begin
                store_d.pri = {store_q.pri[WORD_W-2:0], sdata};
            end
        end

        if (mode == MODE_PAR) begin
            if (lo_rise) begin
                store_d.pri[BUS_W-1:0] = pbus;
            end
            if (mid_rise) begin
                store_d.pri[MID_LO +: BUS_W] = pbus;
            end
            if (hi_rise) begin
                store_d.pri[HI_LO +: HI_W] = pbus[HI_W-1:0];
            end
            if (ewr_rise) begin
                store_d.enh = pbus;
            end
        end

        if (copy_ok) begin
            store_d.sec = store_q.pri;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign pri_q = store_q.pri;
    assign sec_q = store_q.sec;
    assign enh_q = store_q.enh;

    AST_DIRECT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DIR) |=> ($stable(pri_q) && $stable(sec_q) && $stable(enh_q))); // R10
    AST_HOP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode != MODE_DIR) && hop_rise) |=> (sec_q == $past(pri_q))); // R5
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hop_rise && !load_rise) |=> $stable(sec_q)); // R4
    AST_IDLE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_SER) && load_lvl) |=> ($stable(pri_q) && $stable(enh_q))); // R12
    AST_PAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_PAR) && !lo_rise && !mid_rise && !hi_rise) |=> $stable(pri_q)); // R9

endmodule

// File: rtl/cfg_out_mux.sv
module cfg_out_mux #(
    parameter int WORD_W = 20,
    parameter int ENH_W  = 8
) (
    input  logic              direct_sel,
    input  logic              fsel,
    input  logic              enh_en_n,
    input  logic [WORD_W-1:0] pri,
    input  logic [WORD_W-1:0] sec,
    input  logic [ENH_W-1:0]  enh,
    input  logic [WORD_W-1:0] direct_word,
    output logic [WORD_W-1:0] div_word,
    output logic [ENH_W-1:0]  enh_bits
);

    always_comb begin
        if (direct_sel) begin
            div_word = direct_word;
        end else if (fsel) begin
            div_word = pri;
        end else begin
            div_word = sec;
        end
        enh_bits = (!enh_en_n && !direct_sel) ? enh : '0;
    end

endmodule

// File: rtl/synth_cfg_frontend.sv
module synth_cfg_frontend
    import synth_cfg_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int HI_W        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_direct,
    input  logic                    mode_serial,
    input  logic                    ser_clk,
    input  logic                    ser_data,
    input  logic                    ser_load_n,
    input  logic                    enh_wr,
    input  logic                    pwr_lo,
    input  logic                    pwr_mid,
    input  logic                    pwr_hi,
    input  logic                    hop_wr,
    input  logic [BUS_W-1:0]        pbus,
    input  logic                    fsel,
    input  logic                    enh_en_n,
    input  logic [2*BUS_W+HI_W-1:0] direct_word,
    output logic [2*BUS_W+HI_W-1:0] div_word,
    output logic [BUS_W-1:0]        enh_bits
);

    localparam int WORD_W   = 2*BUS_W + HI_W;
    localparam int IX_HOP   = 0;
    localparam int IX_HI    = 1;
    localparam int IX_MID   = 2;
    localparam int IX_LO    = 3;
    localparam int IX_EWR   = 4;
    localparam int IX_LOAD  = 5;
    localparam int IX_SCLK  = 6;
    localparam int EDGE_W   = 7;
    localparam int IX_SMODE = 7;
    localparam int IX_BMODE = 8;
    localparam int IX_SDATA = 9;
    localparam int IX_PBUS  = 10;
    localparam int SYNC_W   = IX_PBUS + BUS_W;

    logic [SYNC_W-1:0] raw_vec;
    logic [SYNC_W-1:0] lvl;
    logic [EDGE_W-1:0] rise;
    cfg_mode_e         mode;
    logic [WORD_W-1:0] pri_q;
    logic [WORD_W-1:0] sec_q;
    logic [BUS_W-1:0]  enh_q;
    logic              unused_levels;

    assign raw_vec = {pbus, ser_data, mode_direct, mode_serial, ser_clk, ser_load_n,
                      enh_wr, pwr_lo, pwr_mid, pwr_hi, hop_wr};

    cfg_edge_sync #(
        .W      (SYNC_W),
        .EDGE_W (EDGE_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (raw_vec),
        .level  (lvl),
        .rise   (rise)
    );

    assign mode          = decode_mode(lvl[IX_BMODE], lvl[IX_SMODE]);
    assign unused_levels = ^{lvl[IX_HOP], lvl[IX_HI], lvl[IX_MID], lvl[IX_LO], lvl[IX_SCLK]};

    cfg_word_store #(
        .BUS_W (BUS_W),
        .HI_W  (HI_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .sclk_rise (rise[IX_SCLK]),
        .sdata     (lvl[IX_SDATA]),
        .load_lvl  (lvl[IX_LOAD]),
        .load_rise (rise[IX_LOAD]),
        .ewr_lvl   (lvl[IX_EWR]),
        .ewr_rise  (rise[IX_EWR]),
        .lo_rise   (rise[IX_LO]),
        .mid_rise  (rise[IX_MID]),
        .hi_rise   (rise[IX_HI]),
        .hop_rise  (rise[IX_HOP]),
        .pbus      (lvl[IX_PBUS +: BUS_W]),
        .pri_q     (pri_q),
        .sec_q     (sec_q),
        .enh_q     (enh_q)
    );

    cfg_out_mux #(
        .WORD_W (WORD_W),
        .ENH_W  (BUS_W)
    ) u_mux (
        .direct_sel  (mode_direct),
        .fsel        (fsel),
        .enh_en_n    (enh_en_n),
        .pri         (pri_q),
        .sec         (sec_q),
        .enh         (enh_q),
        .direct_word (direct_word),
        .div_word    (div_word),
        .enh_bits    (enh_bits)
    );

    AST_ENH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_en_n || mode_direct) |-> (enh_bits == '0)); // R11
    AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_direct |-> (div_word == direct_word)); // R10

endmodule

// File: tb/sim_synth_cfg_frontend.sv
`timescale 1ns/1ps
module sim_synth_cfg_frontend;

    localparam int BUS_W  = 8;
    localparam int HI_W   = 4;
    localparam int SYNC   = 3;
    localparam int WORD_W = 2*BUS_W + HI_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_direct = 1'b0;
    logic              mode_serial = 1'b0;
    logic              ser_clk = 1'b0;
    logic              ser_data = 1'b0;
    logic              ser_load_n = 1'b1;
    logic              enh_wr = 1'b0;
    logic              pwr_lo = 1'b0;
    logic              pwr_mid = 1'b0;
    logic              pwr_hi = 1'b0;
    logic              hop_wr = 1'b0;
    logic [BUS_W-1:0]  pbus = '0;
    logic              fsel = 1'b0;
    logic              enh_en_n = 1'b0;
    logic [WORD_W-1:0] direct_word = '0;
    logic [WORD_W-1:0] div_word;
    logic [BUS_W-1:0]  enh_bits;

    logic [WORD_W-1:0] m_pri = '0;
    logic [WORD_W-1:0] m_sec = '0;
    logic [BUS_W-1:0]  m_enh = '0;
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    synth_cfg_frontend #(
        .BUS_W       (BUS_W),
        .HI_W        (HI_W),
        .SYNC_STAGES (SYNC)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_direct (mode_direct),
        .mode_serial (mode_serial),
        .ser_clk     (ser_clk),
        .ser_data    (ser_data),
        .ser_load_n  (ser_load_n),
        .enh_wr      (enh_wr),
        .pwr_lo      (pwr_lo),
        .pwr_mid     (pwr_mid),
        .pwr_hi      (pwr_hi),
        .hop_wr      (hop_wr),
        .pbus        (pbus),
        .fsel        (fsel),
        .enh_en_n    (enh_en_n),
        .direct_word (direct_word),
        .div_word    (div_word),
        .enh_bits    (enh_bits)
    );

    function automatic logic [WORD_W-1:0] exp_div(input logic f);
        if (mode_direct) return direct_word;
        return f ? m_pri : m_sec;
    endfunction

    function automatic logic [BUS_W-1:0] exp_enh(input logic en_n);
        return (!en_n && !mode_direct) ? m_enh : '0;
    endfunction

    task automatic settle();
        repeat (SYNC + 2) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        for (int f = 0; f < 2; f++) begin
            fsel = f[0];
            #1;
            chk({req, " R6 div_word"}, 32'(div_word), 32'(exp_div(fsel)));
        end
        enh_en_n = 1'b0;
        #1;
        chk({req, " R11 enh_bits"}, 32'(enh_bits), 32'(exp_enh(1'b0)));
        enh_en_n = 1'b1;
        #1;
        chk({req, " R11 enh_bits gated"}, 32'(enh_bits), 32'(exp_enh(1'b1)));
        enh_en_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_mode(input logic d, input logic s);
        mode_direct = d;
        mode_serial = s;
        settle();
    endtask

    task automatic pulse_sclk(input logic b, input logic act_shift, input logic to_enh);
        ser_data = b;
        settle();
        ser_clk = 1'b1;
        settle();
        ser_clk = 1'b0;
        settle();
        if (act_shift) begin
            if (to_enh) m_enh = {m_enh[BUS_W-2:0], b};
            else        m_pri = {m_pri[WORD_W-2:0], b};
        end
    endtask

    // serial mode must be active; loads n bits MSB first, then releases the load line
    task automatic ser_bits(input logic [31:0] w, input int n, input logic to_enh);
        enh_wr = to_enh;
        settle();
        ser_load_n = 1'b0;
        settle();
        for (int i = n - 1; i >= 0; i--) begin
            pulse_sclk(w[i], 1'b1, to_enh);
        end
        ser_load_n = 1'b1;
        settle();
        m_sec = m_pri;
        enh_wr = 1'b0;
        settle();
    endtask

    // sel: 0 lo, 1 mid, 2 hi, 3 enhancement; applies model only when honoured
    task automatic par_write(input int sel, input logic [BUS_W-1:0] d, input logic honoured);
        pbus = d;
        settle();
        case (sel)
            0: pwr_lo  = 1'b1;
            1: pwr_mid = 1'b1;
            2: pwr_hi  = 1'b1;
            default: enh_wr = 1'b1;
        endcase
        settle();
        pwr_lo = 1'b0; pwr_mid = 1'b0; pwr_hi = 1'b0; enh_wr = 1'b0;
        settle();
        if (honoured) begin
            case (sel)
                0: m_pri[7:0]   = d;
                1: m_pri[15:8]  = d;
                2: m_pri[19:16] = d[3:0];
                default: m_enh  = d;
            endcase
        end
    endtask

    task automatic do_hop(input logic honoured);
        hop_wr = 1'b1;
        settle();
        hop_wr = 1'b0;
        settle();
        if (honoured) m_sec = m_pri;
    endtask

    task automatic direct_episode(input logic [WORD_W-1:0] dw);
        logic prev_s;
        prev_s = mode_serial;
        direct_word = dw;
        set_mode(1'b1, prev_s);
        check_outputs("R10 direct pass");
        par_write(0, 8'(($urandom)), 1'b0);
        par_write(2, 8'(($urandom)), 1'b0);
        par_write(3, 8'(($urandom)), 1'b0);
        do_hop(1'b0);
        ser_load_n = 1'b0;
        settle();
        pulse_sclk(1'b1, 1'b0, 1'b0);
        ser_load_n = 1'b1;
        settle();
        set_mode(1'b0, prev_s);
        check_outputs("R10 registers kept");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20511));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1: reset state
        check_outputs("R1 reset");

        // R7: parallel slices
        par_write(0, 8'hA5, 1'b1);
        check_outputs("R7 lo slice");
        par_write(1, 8'h3C, 1'b1);
        par_write(2, 8'hF9, 1'b1);
        check_outputs("R7 full word");
        fsel = 1'b1; #1;
        chk("R7 word layout", 32'(div_word), 32'h93CA5);
        @(negedge clk);

        // R5: hop copy
        do_hop(1'b1);
        check_outputs("R5 hop parallel");

        // R8: parallel enhancement write
        par_write(3, 8'h5A, 1'b1);
        check_outputs("R8 enh parallel");

        // R2 and R4: serial primary load, MSB first, copy on load release
        set_mode(1'b0, 1'b1);
        ser_bits(32'hC3A5F, WORD_W, 1'b0);
        fsel = 1'b0; #1;
        chk("R2 R4 serial word", 32'(div_word), 32'hC3A5F);
        @(negedge clk);
        check_outputs("R2 serial");

        // R3: serial enhancement load
        ser_bits(32'h96, BUS_W, 1'b1);
        enh_en_n = 1'b0; #1;
        chk("R3 serial enh", 32'(enh_bits), 32'h96);
        @(negedge clk);
        check_outputs("R3 serial enh");

        // R12: serial clock with load line high
        pulse_sclk(1'b1, 1'b0, 1'b0);
        pulse_sclk(1'b0, 1'b0, 1'b0);
        check_outputs("R12 idle clocks");

        // R9: parallel strobes ignored in serial mode
        par_write(0, 8'h11, 1'b0);
        par_write(2, 8'h07, 1'b0);
        check_outputs("R9 par in serial");

        // R9: serial shifts ignored in parallel mode, load release does not copy
        set_mode(1'b0, 1'b0);
        m_pri = m_pri; // unchanged by what follows
        ser_load_n = 1'b0;
        settle();
        pulse_sclk(1'b1, 1'b0, 1'b0);
        ser_load_n = 1'b1;
        settle();
        check_outputs("R9 ser in parallel");

        // R10: direct mode
        direct_episode(20'h5F0A3);

        // random mix
        for (int it = 0; it < 120; it++) begin
            int op;
            op = $urandom_range(0, 5);
            case (op)
                0: begin
                    set_mode(1'b0, 1'b1);
                    ser_bits($urandom, $urandom_range(1, WORD_W), 1'b0);
                    check_outputs("R2 random");
                end
                1: begin
                    set_mode(1'b0, 1'b1);
                    ser_bits($urandom, BUS_W, 1'b1);
                    check_outputs("R3 random");
                end
                2: begin
                    set_mode(1'b0, 1'b0);
                    par_write($urandom_range(0, 2), 8'($urandom), 1'b1);
                    check_outputs("R7 random");
                end
                3: begin
                    set_mode(1'b0, 1'b0);
                    par_write(3, 8'($urandom), 1'b1);
                    check_outputs("R8 random");
                end
                4: begin
                    set_mode(1'b0, 1'($urandom_range(0, 1)));
                    do_hop(1'b1);
                    check_outputs("R5 random");
                end
                default: begin
                    direct_episode(WORD_W'($urandom));
                end
            endcase
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule